// File: doc/BRIEF.md
# Serial Transfer Pause Controller

This block sits beside the shift and command logic of a serial SRAM slave. It lets the bus master freeze a transfer partway through by pulling an active-low pause pin low. The bit counters, opcode and address held by the neighbouring logic are kept, so the sequence carries on from the same point once the pin is released. It drives two signals. A registered freeze signal stops the shift and command logic. A combinational output-release signal forces the serial data output to high impedance.

The freeze is tied to the serial clock level. A change on the pin while the serial clock is low takes effect at once. A change while the clock is high waits until the clock next goes low, which is the falling edge. The output-release signal does not wait for the clock. It follows the synchronized pin level directly. The pin has no pause function in four-bit mode, because it then carries a data line. Deselecting the device clears any pause, whether it is waiting or already active.

The pause pin is asynchronous and passes through a two-flop synchronizer. Chip select, the serial clock level and the four-bit flag are taken as already synchronous to the core clock.

Top module: `serhold_unit`

## Requirements
- R1: After reset, with the pause pin high, `pause_o` and `so_hiz_o` are both 0.
- R2: With the device selected and the serial clock low, a falling pause pin raises `pause_o` three core clocks later: two synchronizer stages, then one state register.
- R3: If the serial clock is high when the synchronized pin goes low, `pause_o` stays 0 until the first core clock that samples the serial clock low. `pause_o` reads 1 one core clock after that sample.
- R4: While paused with the serial clock low, a rising pause pin clears `pause_o` one core clock after the synchronized level rises, which is three clocks after the pin.
- R5: While paused with the serial clock high, releasing the pin keeps `pause_o` at 1 until the serial clock is sampled low. `pause_o` clears one core clock after that sample.
- R6: `so_hiz_o` is 1 exactly while the synchronized pin is low, the device is selected and four-bit mode is off. It changes two core clocks after the pin, whatever the serial clock level.
- R7: With four-bit mode on (`quad_mode_i` = 1), `pause_o` and `so_hiz_o` stay 0 whatever the pin does. Turning four-bit mode on during a pause clears `pause_o` on the next core clock.
- R8: Chip select high (`cs_n_i` = 1) forces `so_hiz_o` to 0 at once and clears `pause_o` on the next core clock. This applies to an active pause and to one still waiting for the clock to go low.
- R9: A pin pulse that begins and ends while the serial clock stays high never asserts `pause_o`.
- R10: While paused with the pin low, toggling the serial clock leaves `pause_o` at 1. If the pin falls again while a release is waiting, the pause is kept when the clock goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_n_i | input | 1 | Asynchronous active-low pause pin |
| cs_n_i | input | 1 | Active-low chip select, synchronous to clk |
| sck_i | input | 1 | Serial clock level, already synchronized to clk |
| quad_mode_i | input | 1 | 1 when four-bit mode is active |
| pause_o | output | 1 | Freeze request to the shift and command logic |
| so_hiz_o | output | 1 | Forces the serial data output to high impedance |

## Verification
The assertions assume that chip select, the serial clock level and the four-bit flag are stable across each core clock edge and already synchronous. They also assume that a freeze can begin only from a synchronized low pin level. The bench changes every input on the falling core clock edge and holds each serial clock level for at least one full core clock. Each freeze entry and exit therefore has a single well-defined sampling cycle. Every expected output edge is counted from that cycle through the synchronizer and the state register.

// File: rtl/serhold_pkg.sv
// Package: shared types for the serial pause controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package serhold_pkg;

    // Number of synchronizer stages on the asynchronous pause pin.
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Freeze state machine encoding.
    typedef enum logic [1:0] {
        HS_RUN        = 2'd0,  // transfer running, no request
        HS_ENTER_WAIT = 2'd1,  // request seen with clock high, waiting for low
        HS_PAUSED     = 2'd2,  // transfer frozen
        HS_EXIT_WAIT  = 2'd3   // release seen with clock high, still frozen
    } hs_state_e;

    // True when a state keeps the transfer frozen.
    function automatic logic hs_is_frozen(input hs_state_e s);
        return (s == HS_PAUSED) || (s == HS_EXIT_WAIT);
    endfunction

endpackage

// File: rtl/serhold_sync.sv
// Module: serhold_sync
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2 and a synchronous active-low reset.
// The output resets to RESET_VAL.
module serhold_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[TOP-1:0], async_i};
        end
    end

    assign sync_o = chain_q[TOP];

endmodule

// File: rtl/serhold_sck_qual.sv
// Module: serhold_sck_qual
// Decides when a freeze change may take effect. A change is allowed
// while the serial clock sits at its low level. When the clock is
// high, the first low sample after it is the falling edge, so a
// waiting change lands exactly there. Also flags the falling edge
// itself so the checker can relate deferred changes to it.
// Assumes sck_i is already synchronous to clk.
module serhold_sck_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic apply_ok_o,
    output logic sck_fall_o
);

    logic sck_q;

    // Remember the previous clock level to find the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck_i;
        end
    end

    // Changes land only while the serial clock is low.
    assign apply_ok_o = ~sck_i;
    assign sck_fall_o = sck_q & ~sck_i;

endmodule

// File: rtl/serhold_fsm.sv
// Module: serhold_fsm
// Four-state freeze controller. A request or release seen while the
// serial clock is high is held in a wait state until apply_ok_i says
// the clock is low. Deselect or four-bit mode returns to RUN at once.
// Assumes the inputs are synchronous to clk. Synchronous active-low
// reset.
module serhold_fsm
    import serhold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_i,   // synchronized pin level is low
    input  logic cs_n_i,
    input  logic quad_mode_i,
    input  logic apply_ok_i,
    input  logic sck_fall_i,
    output logic pause_o
);

    hs_state_e state_q, state_d;
    logic      abort;
    logic      want;

    assign abort = cs_n_i | quad_mode_i;
    assign want  = hold_req_i & ~abort;

    // Next-state selection for entering and leaving the freeze.
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = HS_RUN;
        end else begin
            unique case (state_q)
                HS_RUN: begin
                    if (want) state_d = apply_ok_i ? HS_PAUSED : HS_ENTER_WAIT;
                end
                HS_ENTER_WAIT: begin
                    if (!want)          state_d = HS_RUN;
                    else if (apply_ok_i) state_d = HS_PAUSED;
                end
                HS_PAUSED: begin
                    if (!want) state_d = apply_ok_i ? HS_RUN : HS_EXIT_WAIT;
                end
                HS_EXIT_WAIT: begin
                    if (want)            state_d = HS_PAUSED;
                    else if (apply_ok_i) state_d = HS_RUN;
                end
                default: state_d = HS_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    assign pause_o = hs_is_frozen(state_q);

    // R8: deselect ends any freeze on the next clock.
    p_deselect_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !pause_o);

    // R7: four-bit mode ends any freeze on the next clock.
    p_quad_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        quad_mode_i |=> !pause_o);

    // R3: a freeze only starts from a clock-low sample.
    p_enter_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_o) |-> $past(apply_ok_i));

    // R2: a freeze only starts from a requested pin level.
    p_enter_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_o) |-> $past(hold_req_i));

    // R5: a freeze ends only on a clock-low sample or an abort.
    p_exit_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pause_o) |-> ($past(apply_ok_i) || $past(abort)));

    // R10: a frozen transfer with the pin still low stays frozen over a falling edge.
    p_hold_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_o && hold_req_i && !abort && sck_fall_i) |=> pause_o);

endmodule

// File: rtl/serhold_unit.sv
// Module: serhold_unit (top)
// Pause controller for a serial SRAM slave. Synchronizes the
// active-low pause pin, qualifies freeze changes by the serial clock
// level, and drives an immediate output-release signal from the
// synchronized level.
// Assumes cs_n_i, sck_i and quad_mode_i are synchronous to clk.
module serhold_unit #(
    parameter int unsigned SYNC_STAGES = serhold_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n_i,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic quad_mode_i,
    output logic pause_o,
    output logic so_hiz_o
);

    logic hold_n_sync;
    logic apply_ok;
    logic sck_fall;
    logic hold_req;

    // Bring the asynchronous pin into the core clock domain.
    serhold_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (hold_n_pin_gate(hold_n_i)),
        .sync_o  (hold_n_sync)
    );

    // Identity gate kept as a function so the pin path stays explicit.
    function automatic logic hold_n_pin_gate(input logic v);
        return v;
    endfunction

    // Decide when freeze changes may land.
    serhold_sck_qual u_sck (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .apply_ok_o (apply_ok),
        .sck_fall_o (sck_fall)
    );

    assign hold_req = ~hold_n_sync;

    // Freeze state machine.
    serhold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_req_i  (hold_req),
        .cs_n_i      (cs_n_i),
        .quad_mode_i (quad_mode_i),
        .apply_ok_i  (apply_ok),
        .sck_fall_i  (sck_fall),
        .pause_o     (pause_o)
    );

    // Output release follows the synchronized level with no clock qualification.
    always_comb begin
        so_hiz_o = hold_req & ~cs_n_i & ~quad_mode_i;
    end

    // R6: a freeze is never active while the output is being driven during a held pin.
    p_hiz_with_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_o && !cs_n_i && !quad_mode_i && $stable(hold_n_sync) && !hold_n_sync) |-> so_hiz_o);

endmodule

// File: tb/serhold_unit_tb_top.sv
// Directed bench for serhold_unit: one task per scenario.
module serhold_unit_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic hold_n, cs_n, sck, quad;
    logic pause, so_hiz;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    serhold_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_n_i    (hold_n),
        .cs_n_i      (cs_n),
        .sck_i       (sck),
        .quad_mode_i (quad),
        .pause_o     (pause),
        .so_hiz_o    (so_hiz)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic idle();
        hold_n = 1'b1; cs_n = 1'b0; sck = 1'b0; quad = 1'b0;
        tick(4);
    endtask

    // Reach the frozen state with the clock low.
    task automatic go_paused();
        idle();
        hold_n = 1'b0;
        tick(3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hold_n = 1'b1; cs_n = 1'b1; sck = 1'b0; quad = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1", "pause after reset", pause, 1'b0);
        chk("R1", "so_hiz after reset", so_hiz, 1'b0);
    endtask

    task automatic t_enter_low();
        idle();
        hold_n = 1'b0;
        tick(2);
        chk("R6", "so_hiz two clocks after pin", so_hiz, 1'b1);
        chk("R2", "pause not yet", pause, 1'b0);
        tick(1);
        chk("R2", "pause third clock", pause, 1'b1);
    endtask

    task automatic t_enter_high();
        idle();
        sck = 1'b1;
        tick(1);
        hold_n = 1'b0;
        tick(5);
        chk("R3", "pause deferred while clock high", pause, 1'b0);
        chk("R6", "so_hiz ignores clock level", so_hiz, 1'b1);
        sck = 1'b0;
        tick(1);
        chk("R3", "pause at falling edge", pause, 1'b1);
    endtask

    task automatic t_exit_low();
        go_paused();
        hold_n = 1'b1;
        tick(2);
        chk("R6", "so_hiz drops two clocks after pin", so_hiz, 1'b0);
        chk("R4", "pause still set", pause, 1'b1);
        tick(1);
        chk("R4", "pause cleared", pause, 1'b0);
    endtask

    task automatic t_exit_high();
        go_paused();
        sck = 1'b1;
        tick(1);
        hold_n = 1'b1;
        tick(5);
        chk("R5", "pause kept while clock high", pause, 1'b1);
        chk("R6", "so_hiz off while clock high", so_hiz, 1'b0);
        sck = 1'b0;
        tick(1);
        chk("R5", "pause cleared at falling edge", pause, 1'b0);
    endtask

    task automatic t_clock_ignored();
        go_paused();
        for (int i = 0; i < 6; i++) begin
            sck = ~sck;
            tick(1);
        end
        chk("R10", "pause survives clock toggling", pause, 1'b1);
        sck = 1'b1;
        tick(1);
        hold_n = 1'b1;
        tick(4);
        hold_n = 1'b0;
        tick(4);
        sck = 1'b0;
        tick(2);
        chk("R10", "re-held during exit wait", pause, 1'b1);
    endtask

    task automatic t_short_pulse();
        idle();
        sck = 1'b1;
        tick(1);
        hold_n = 1'b0;
        tick(4);
        hold_n = 1'b1;
        tick(4);
        sck = 1'b0;
        tick(2);
        chk("R9", "pulse within clock high never pauses", pause, 1'b0);
    endtask

    task automatic t_deselect();
        go_paused();
        cs_n = 1'b1;
        #1;
        chk("R8", "so_hiz off at deselect", so_hiz, 1'b0);
        tick(1);
        chk("R8", "active pause cleared", pause, 1'b0);
        idle();
        sck = 1'b1;
        tick(1);
        hold_n = 1'b0;
        tick(4);
        cs_n = 1'b1;
        tick(1);
        sck = 1'b0;
        tick(2);
        chk("R8", "pending pause cleared", pause, 1'b0);
    endtask

    task automatic t_quad();
        idle();
        quad = 1'b1;
        tick(1);
        hold_n = 1'b0;
        tick(4);
        chk("R7", "no pause in four-bit mode", pause, 1'b0);
        chk("R7", "no so_hiz in four-bit mode", so_hiz, 1'b0);
        go_paused();
        quad = 1'b1;
        tick(1);
        chk("R7", "four-bit mode ends pause", pause, 1'b0);
    endtask

    initial begin
        t_reset();
        t_enter_low();
        t_enter_high();
        t_exit_low();
        t_exit_high();
        t_clock_ignored();
        t_short_pulse();
        t_deselect();
        t_quad();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule